// File: doc/BRIEF.md
# Floppy Controller Data FIFO with Service Threshold

This block sits between the host's data register port and the disk formatter of a floppy controller. It stores data bytes while a sector transfer is running, tells the host through the request-for-master and direction bits when it may move a byte, and raises a request to the DMA unit when the fill level passes a programmable threshold. Bytes that arrive from the disk too fast, or are needed by the formatter before the host has supplied them, are detected as overrun or underrun.

After reset the queue is switched off and the data register behaves as a one-byte holding buffer. A configure operation (a one-cycle write of an enable bit and a 4-bit threshold) turns on the full 16-entry queue. Command and result bytes, moved outside the execution phase, always pass through with a capacity of one byte. When the execution phase starts, the queue is emptied and the transfer direction is latched. A write underrun stops the transfer and feeds zero bytes to the formatter so the sector can be finished. A read overrun stops accepting disk bytes and lets the host drain what is already stored.

Top module: `fdc_fifo_top`

## Requirements
- R1: After reset err=0, dma_req=0, and with disk_dir=0 rqm=1 and dio=0; the queue is disabled, so during an execution phase it holds only one byte and a second disk byte with no host read between is an overrun.
- R2: A configure write with cfg_fifo_en=1 gives a capacity of 16 bytes during the execution phase; a threshold value of 0 acts as 1.
- R3: Bytes leave the queue in the order they entered, on both transfer directions.
- R4: dio equals the transfer direction (1 = the host must read); rqm is 1 when the host may transfer: on reads when the queue holds a byte, on writes when it has space.
- R5: During the execution phase dma_req is 1 on reads when the fill level is at least the threshold and on writes when the free space is at least the threshold; after a read phase ends with bytes left, dma_req stays 1 until the queue is empty.
- R6: exec_start empties the queue, so right after it rqm is 0 for a read and 1 for a write.
- R7: A disk byte offered to a full queue in a read execution phase is dropped, sets err, and ends disk acceptance; the stored bytes are still delivered to the host with rqm=1 and dma_req=1 until the queue is empty.
- R8: A disk byte request from an empty queue in a write execution phase sets err; from then until exec_end disk_rdata is 00h, rqm=0, dma_req=0, and host writes are ignored.
- R9: err stays 1 until the next exec_start, which clears it.
- R10: Outside the execution phase dma_req is 0 and a host write fills the single byte buffer (rqm falls to 0), which the formatter then reads on disk_rdata.
- R11: A host write while dio=1, or a host read while dio=0, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configure strobe, loads enable and threshold |
| cfg_fifo_en | input | 1 | 1 enables the 16-byte queue |
| cfg_thresh | input | 4 | Service threshold in bytes (0 acts as 1) |
| exec_start | input | 1 | Execution phase begins (pulse) |
| exec_end | input | 1 | Execution phase ends (pulse) |
| disk_dir | input | 1 | Transfer direction: 1 disk to host, 0 host to disk |
| disk_stb | input | 1 | Formatter byte strobe (push on reads, pop on writes) |
| disk_wdata | input | 8 | Byte from the formatter |
| disk_rdata | output | 8 | Byte to the formatter (00h while padding) |
| host_wr | input | 1 | Host data register write strobe |
| host_rd | input | 1 | Host data register read strobe |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Byte presented to the host |
| rqm | output | 1 | Host may transfer a byte |
| dio | output | 1 | 1 = host read needed, 0 = host write needed |
| dma_req | output | 1 | Request to the DMA unit |
| err | output | 1 | Overrun or underrun occurred |

## Verification
The queue is driven with interleaved write-then-drain and fill-then-read sequences around a threshold of three, which separates a request keyed on fill level from one keyed on free space and shows ordering across both directions. Filling to exactly sixteen and one past, and draining to empty and one past, separates correct full and empty detection from off-by-one capacity and shows the dropped byte and the zero padding. The disabled mode, a zero threshold and an execution phase started over leftover bytes tell the one-byte bypass, the threshold clamp and the flush apart from the ordinary path.

// File: rtl/fdc_fifo_pkg.sv
package fdc_fifo_pkg;
  // transfer phase of the data path
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,  // command / result bytes, one-byte buffer
    PH_EXEC  = 2'd1,  // sector data moving
    PH_DRAIN = 2'd2,  // read finished or overran, host empties queue
    PH_PAD   = 2'd3   // write underran, formatter fed zero bytes
  } phase_e;
endpackage

// File: rtl/fdc_fifo_store.sv
module fdc_fifo_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] count_q, count_d;
  logic          wr_en;

  always_comb begin
    wr_en    = push && !flush;
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
    end else begin
      if (push) wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (pop)  rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      if (push && !pop)      count_d = count_q + 1'b1;
      else if (pop && !push) count_d = count_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_ptr_q] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  assign head  = mem_q[rd_ptr_q];
  assign count = count_q;
endmodule

// File: rtl/fdc_fifo_ctrl.sv
module fdc_fifo_ctrl
  import fdc_fifo_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec_start,
  input  logic          exec_end,
  input  logic          disk_dir,
  input  logic          disk_stb,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] cap,
  output phase_e        phase,
  output logic          rd_dir,
  output logic          push,
  output logic          pop,
  output logic          flush,
  output logic          err
);
  phase_e phase_q, phase_d;
  logic   dir_q, dir_d;
  logic   err_q, err_d;
  logic   empty, full, active;
  logic   push_req, pop_req, overrun, underrun;

  always_comb begin
    rd_dir = (phase_q == PH_IDLE) ? disk_dir : dir_q;
    empty  = (count == '0);
    full   = (count >= cap);
    active = (phase_q == PH_IDLE) || (phase_q == PH_EXEC);

    if (rd_dir) begin
      push_req = disk_stb && active;
      pop_req  = host_rd && (active || phase_q == PH_DRAIN);
    end else begin
      push_req = host_wr && active;
      pop_req  = disk_stb && active;
    end

    overrun  = rd_dir  && (phase_q == PH_EXEC) && disk_stb && full;
    underrun = !rd_dir && (phase_q == PH_EXEC) && disk_stb && empty;
    push     = push_req && !full;
    pop      = pop_req && !empty;

    phase_d = phase_q;
    dir_d   = dir_q;
    err_d   = err_q;
    flush   = 1'b0;
    if (exec_start) begin
      phase_d = PH_EXEC;
      dir_d   = disk_dir;
      err_d   = 1'b0;
      flush   = 1'b1;
    end else begin
      unique case (phase_q)
        PH_EXEC: begin
          if (overrun) begin
            err_d   = 1'b1;
            phase_d = PH_DRAIN;
          end else if (underrun) begin
            err_d   = 1'b1;
            phase_d = PH_PAD;
            flush   = 1'b1;
          end else if (exec_end) begin
            if (rd_dir && !empty) begin
              phase_d = PH_DRAIN;
            end else begin
              phase_d = PH_IDLE;
              flush   = 1'b1;
            end
          end
        end
        PH_DRAIN: if (empty) phase_d = PH_IDLE;
        PH_PAD:   if (exec_end) phase_d = PH_IDLE;
        default:  phase_d = phase_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      dir_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      dir_q   <= dir_d;
      err_q   <= err_d;
    end
  end

  assign phase = phase_q;
  assign err   = err_q;
endmodule

// File: rtl/fdc_fifo_req.sv
module fdc_fifo_req
  import fdc_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = 5,
  parameter int TW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_fifo_en,
  input  logic [TW-1:0] cfg_thresh,
  input  phase_e        phase,
  input  logic          rd_dir,
  input  logic [CW-1:0] count,
  output logic [CW-1:0] cap,
  output logic          rqm,
  output logic          dma_req
);
  logic          en_q, en_d;
  logic [TW-1:0] thr_q, thr_d;
  logic [CW-1:0] thr_eff, free;
  logic          empty;

  always_comb begin
    en_d  = cfg_we ? cfg_fifo_en : en_q;
    thr_d = cfg_we ? cfg_thresh  : thr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      thr_q <= '0;
    end else begin
      en_q  <= en_d;
      thr_q <= thr_d;
    end
  end

  always_comb begin
    cap     = (en_q && phase != PH_IDLE) ? CW'(DEPTH) : CW'(1);
    if (!en_q || thr_q == '0) thr_eff = CW'(1);
    else                      thr_eff = CW'(thr_q);
    free    = (count >= cap) ? '0 : cap - count;
    empty   = (count == '0);
    rqm     = 1'b0;
    dma_req = 1'b0;
    unique case (phase)
      PH_IDLE: rqm = rd_dir ? !empty : (free != '0);
      PH_EXEC: begin
        rqm     = rd_dir ? !empty : (free != '0);
        dma_req = rd_dir ? (count >= thr_eff) : (free >= thr_eff);
      end
      PH_DRAIN: begin
        rqm     = !empty;
        dma_req = !empty;
      end
      default: begin
        rqm     = 1'b0;
        dma_req = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/fdc_fifo_top.sv
module fdc_fifo_top
  import fdc_fifo_pkg::*;
#(
  parameter  int DW    = 8,
  parameter  int DEPTH = 16,
  localparam int TW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_fifo_en,
  input  logic [TW-1:0] cfg_thresh,
  input  logic          exec_start,
  input  logic          exec_end,
  input  logic          disk_dir,
  input  logic          disk_stb,
  input  logic [DW-1:0] disk_wdata,
  output logic [DW-1:0] disk_rdata,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          rqm,
  output logic          dio,
  output logic          dma_req,
  output logic          err
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [1:0]    rst_sync_q;
  logic          core_rst_n;
  phase_e        phase;
  logic          rd_dir, push, pop, flush;
  logic [CW-1:0] count, cap;
  logic [DW-1:0] head, wdata;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  assign wdata = rd_dir ? disk_wdata : host_wdata;

  fdc_fifo_store #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_store (
    .clk   (clk),
    .rst_n (core_rst_n),
    .flush (flush),
    .push  (push),
    .pop   (pop),
    .wdata (wdata),
    .head  (head),
    .count (count)
  );

  fdc_fifo_ctrl #(.CW(CW)) u_ctrl (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .exec_start (exec_start),
    .exec_end   (exec_end),
    .disk_dir   (disk_dir),
    .disk_stb   (disk_stb),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .count      (count),
    .cap        (cap),
    .phase      (phase),
    .rd_dir     (rd_dir),
    .push       (push),
    .pop        (pop),
    .flush      (flush),
    .err        (err)
  );

  fdc_fifo_req #(.DEPTH(DEPTH), .CW(CW), .TW(TW)) u_req (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .cfg_we      (cfg_we),
    .cfg_fifo_en (cfg_fifo_en),
    .cfg_thresh  (cfg_thresh),
    .phase       (phase),
    .rd_dir      (rd_dir),
    .count       (count),
    .cap         (cap),
    .rqm         (rqm),
    .dma_req     (dma_req)
  );

  assign host_rdata = head;
  assign disk_rdata = (phase == PH_PAD) ? '0 : head;
  assign dio        = rd_dir;
endmodule

// File: rtl/fdc_fifo_chk.sv
module fdc_fifo_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          exec_start,
  input logic          disk_dir,
  input logic [DW-1:0] disk_rdata,
  input logic          rqm,
  input logic          dio,
  input logic          dma_req,
  input logic          err
);
  // R5: the DMA unit is only asked when the host side may move a byte
  assert_dma_needs_rqm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> rqm);

  // R6: a new execution phase starts from an empty queue
  assert_flush_on_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |=> (rqm != $past(disk_dir)));

  // R9: err cleared by the next command start
  assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |=> !err);

  // R9: err holds until a start arrives
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !exec_start) |=> err);

  // R8: a write underrun stops host service and pads with zeros
  assert_pad_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(err) && !dio) |-> (!rqm && !dma_req && disk_rdata == '0));
endmodule

bind fdc_fifo_top fdc_fifo_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .exec_start (exec_start),
  .disk_dir   (disk_dir),
  .disk_rdata (disk_rdata),
  .rqm        (rqm),
  .dio        (dio),
  .dma_req    (dma_req),
  .err        (err)
);

// File: tb/fdc_fifo_top_tb.sv
module fdc_fifo_top_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we, cfg_fifo_en;
  logic [3:0] cfg_thresh;
  logic       exec_start, exec_end, disk_dir, disk_stb;
  logic [7:0] disk_wdata, disk_rdata;
  logic       host_wr, host_rd;
  logic [7:0] host_wdata, host_rdata;
  logic       rqm, dio, dma_req, err;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  fdc_fifo_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_fifo_en(cfg_fifo_en),
    .cfg_thresh(cfg_thresh), .exec_start(exec_start), .exec_end(exec_end),
    .disk_dir(disk_dir), .disk_stb(disk_stb), .disk_wdata(disk_wdata),
    .disk_rdata(disk_rdata), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .rqm(rqm), .dio(dio),
    .dma_req(dma_req), .err(err)
  );

  // {kind[2:0], data[7:0], rqm, dma}; kinds: 0 disk push, 1 host read,
  // 2 host write, 3 disk pop, 4 start read phase, 5 start write phase
  localparam int NV = 15;
  localparam logic [12:0] VEC [NV] = '{
    {3'd5, 8'h00, 1'b1, 1'b1},
    {3'd2, 8'h11, 1'b1, 1'b1},
    {3'd2, 8'h22, 1'b1, 1'b1},
    {3'd3, 8'h11, 1'b1, 1'b1},
    {3'd3, 8'h22, 1'b1, 1'b1},
    {3'd4, 8'h00, 1'b0, 1'b0},
    {3'd0, 8'h33, 1'b1, 1'b0},
    {3'd0, 8'h44, 1'b1, 1'b0},
    {3'd0, 8'h55, 1'b1, 1'b1},
    {3'd1, 8'h33, 1'b1, 1'b0},
    {3'd0, 8'h66, 1'b1, 1'b1},
    {3'd1, 8'h44, 1'b1, 1'b0},
    {3'd1, 8'h55, 1'b1, 1'b0},
    {3'd1, 8'h66, 1'b0, 1'b0},
    {3'd2, 8'h77, 1'b0, 1'b0}
  };

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // every task starts and ends at a falling edge
  task automatic configure(logic en, logic [3:0] thr);
    cfg_we = 1'b1; cfg_fifo_en = en; cfg_thresh = thr;
    @(negedge clk); cfg_we = 1'b0;
  endtask
  task automatic start(logic dir);
    disk_dir = dir; exec_start = 1'b1;
    @(negedge clk); exec_start = 1'b0;
  endtask
  task automatic finish_exec();
    exec_end = 1'b1;
    @(negedge clk); exec_end = 1'b0;
  endtask
  task automatic disk_push(logic [7:0] d);
    disk_stb = 1'b1; disk_wdata = d;
    @(negedge clk); disk_stb = 1'b0;
  endtask
  task automatic disk_pop();
    disk_stb = 1'b1;
    @(negedge clk); disk_stb = 1'b0;
  endtask
  task automatic host_write(logic [7:0] d);
    host_wr = 1'b1; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask
  task automatic host_read();
    host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_fifo_en = 1'b0; cfg_thresh = '0;
    exec_start = 1'b0; exec_end = 1'b0; disk_dir = 1'b0; disk_stb = 1'b0;
    disk_wdata = '0; host_wr = 1'b0; host_rd = 1'b0; host_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1 rqm", 8'(rqm), 8'd1);
    chk("R1 dio", 8'(dio), 8'd0);
    chk("R1 dma", 8'(dma_req), 8'd0);
    chk("R1 err", 8'(err), 8'd0);

    // R10: command byte through the one-byte buffer
    host_write(8'hA5);
    chk("R10 rqm full", 8'(rqm), 8'd0);
    chk("R10 dma idle", 8'(dma_req), 8'd0);
    chk("R10 byte", disk_rdata, 8'hA5);
    disk_pop();
    chk("R10 rqm empty", 8'(rqm), 8'd1);

    // R1: queue disabled, one byte capacity in execution phase
    start(1'b1);
    disk_push(8'hC1);
    chk("R1 rqm one", 8'(rqm), 8'd1);
    chk("R1 dma one", 8'(dma_req), 8'd1);
    disk_push(8'hC2);
    chk("R1 overrun err", 8'(err), 8'd1);
    chk("R1 kept byte", host_rdata, 8'hC1);
    host_read();
    chk("R7 drained rqm", 8'(rqm), 8'd0);
    chk("R9 err held", 8'(err), 8'd1);
    start(1'b0);
    chk("R9 err cleared", 8'(err), 8'd0);
    finish_exec();

    // table: threshold 3 with queue enabled (R3 R4 R5 R11)
    configure(1'b1, 4'd3);
    for (int i = 0; i < NV; i++) begin
      logic [2:0] kind;
      logic [7:0] d;
      kind = VEC[i][12:10];
      d    = VEC[i][9:2];
      case (kind)
        3'd0: disk_push(d);
        3'd1: begin chk("R3 host order", host_rdata, d); host_read(); end
        3'd2: host_write(d);
        3'd3: begin chk("R3 disk order", disk_rdata, d); disk_pop(); end
        3'd4: start(1'b1);
        default: start(1'b0);
      endcase
      chk($sformatf("R4 rqm vec %0d", i), 8'(rqm), 8'(VEC[i][1]));
      chk($sformatf("R5 dma vec %0d", i), 8'(dma_req), 8'(VEC[i][0]));
      chk($sformatf("R4 dio vec %0d", i), 8'(dio), 8'(kind == 3'd4 || (i >= 5)));
    end
    finish_exec();

    // R2: full 16-byte write capacity, R11 extra write ignored
    start(1'b0);
    for (int i = 0; i < 16; i++) host_write(8'h80 + 8'(i));
    chk("R2 full rqm", 8'(rqm), 8'd0);
    chk("R5 full dma", 8'(dma_req), 8'd0);
    host_write(8'hEE);
    for (int i = 0; i < 16; i++) begin
      chk("R3 write order", disk_rdata, 8'h80 + 8'(i));
      disk_pop();
    end
    chk("R11 extra write dropped rqm", 8'(rqm), 8'd1);
    chk("R8 no err yet", 8'(err), 8'd0);

    // R8: underrun pads with zeros
    disk_pop();
    chk("R8 err", 8'(err), 8'd1);
    chk("R8 rqm", 8'(rqm), 8'd0);
    chk("R8 dma", 8'(dma_req), 8'd0);
    chk("R8 pad byte", disk_rdata, 8'h00);
    host_write(8'h5A);
    chk("R8 host write ignored", disk_rdata, 8'h00);
    chk("R8 rqm still low", 8'(rqm), 8'd0);
    finish_exec();
    chk("R9 err after end", 8'(err), 8'd1);

    // R7: read overrun then drain
    start(1'b1);
    chk("R9 cleared on start", 8'(err), 8'd0);
    for (int i = 0; i < 16; i++) disk_push(8'h40 + 8'(i));
    chk("R7 no err at 16", 8'(err), 8'd0);
    disk_push(8'hF0);
    chk("R7 err at 17", 8'(err), 8'd1);
    disk_push(8'hF1);
    for (int i = 0; i < 16; i++) begin
      chk("R7 drain dma", 8'(dma_req), 8'd1);
      chk("R7 drain order", host_rdata, 8'h40 + 8'(i));
      host_read();
    end
    chk("R7 empty rqm", 8'(rqm), 8'd0);
    chk("R7 empty dma", 8'(dma_req), 8'd0);

    // R6: start flushes leftover bytes
    start(1'b0);
    for (int i = 0; i < 5; i++) host_write(8'h10 + 8'(i));
    start(1'b1);
    chk("R6 flushed rqm", 8'(rqm), 8'd0);
    finish_exec();

    // R2: threshold 0 acts as 1
    configure(1'b1, 4'd0);
    start(1'b1);
    disk_push(8'h99);
    chk("R2 thr zero dma", 8'(dma_req), 8'd1);
    host_read();
    finish_exec();

    // R5: read ends below threshold, request held until empty
    configure(1'b1, 4'd3);
    start(1'b1);
    disk_push(8'h2B);
    chk("R5 below thr", 8'(dma_req), 8'd0);
    finish_exec();
    chk("R5 drain dma", 8'(dma_req), 8'd1);
    chk("R5 drain byte", host_rdata, 8'h2B);
    host_read();
    chk("R5 drained dma", 8'(dma_req), 8'd0);
    chk("R5 drained rqm", 8'(rqm), 8'd0);

    summary();
    $finish;
  end
endmodule